// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a parallel NOR flash array and turns the write cycles seen on the host bus into operation requests. Each write reaches it as a single registered bus-write event: an address and a data word, marked by a one-cycle valid strobe. Writes that change the array must be preceded by a two-write unlock key. After the key, a third write picks the command family. Program takes one more write carrying the target word. Erase takes a second key and a final write whose code chooses sector, block or whole-array erase.

The decoder emits one-cycle start pulses for each operation and latches the address and data that the operation acts on. It holds a mode flag for identifier reads, parameter-query reads and secure-region reads. It also recognises single-write shortcuts for erase suspend, erase resume, query entry and mode exit. The array itself, the timers and the status bits are outside this block. A busy input from the operation engine freezes command decoding while an internal operation runs. A write-protect input shields the boot region, which is the top or bottom 2^BOOT_W words of the array, chosen by a parameter.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, every start pulse is low, all three mode flags are low, and the target address and data are zero.
- R2: A sequence opens with data 0xAA at address 0x555, then 0x55 at address 0x2AA. Only address bits 10..0 and data bits 7..0 are compared, so the upper address and data bits are ignored.
- R3: Unlock followed by 0xA0 at 0x555 selects program. The next write is the target word. One cycle after that write is captured, start_prog pulses, tgt_addr holds the full write address and tgt_data holds the full write data.
- R4: Unlock, 0x80 at 0x555, then a second unlock selects erase. The sixth write decides the kind: 0x10 at 0x555 pulses start_chip_erase, 0x50 at any address pulses start_sect_erase, and 0x30 at any address pulses start_blk_erase. For all three, tgt_addr takes the sixth write's address.
- R5: While busy is high and no sequence is open, a single write of 0xB0 to any address pulses erase_susp. While busy is low and no sequence is open, a single write of 0x30 to any address pulses erase_resume, and 0xB0 has no effect.
- R6: Unlock followed by a third write at 0x555 sets a mode: 0x90 sets mode_ident, 0x98 sets mode_query, 0x88 sets mode_secid. A single write of 0x98 to address 0x055 also sets mode_query. At most one flag is high, and a new entry replaces the old one.
- R7: A single write of 0xF0 to any address, or unlock followed by 0xF0 at 0x555, clears all mode flags.
- R8: Any write inside an open sequence that does not match the expected address and code closes the sequence, clears the mode flags and emits no pulse. Later writes are decoded as a fresh start.
- R9: While busy is high, every write except the suspend of R5 is ignored. This includes the exit write. The sequence position and the mode flags are kept.
- R10: With wp_n low, a program, sector erase or block erase whose address lies in the boot region produces no pulse, and a chip erase produces no pulse at all. Addresses outside the boot region proceed normally.
- R11: Unlock followed by 0xA5 at 0x555, then one word write, pulses start_sid_prog. Unlock followed by 0x85 at 0x555, then one write, pulses start_sid_lock. The write-protect input does not affect either.
- R12: Every pulse lasts exactly one cycle and appears in the cycle after the write that completes the command. At most one pulse is high at a time. The output bit order used by the bench is prog, sect, blk, chip, sid_prog, sid_lock, susp, resume (bit 0 to bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe marking a captured bus write |
| wr_addr | input | AW (19) | Word address of the bus write |
| wr_data | input | DW (16) | Data of the bus write |
| busy | input | 1 | Internal program or erase in progress |
| wp_n | input | 1 | Boot-region protection, active low |
| start_prog | output | 1 | Word program start pulse |
| start_sect_erase | output | 1 | Sector erase start pulse |
| start_blk_erase | output | 1 | Block erase start pulse |
| start_chip_erase | output | 1 | Whole-array erase start pulse |
| start_sid_prog | output | 1 | Secure-region word program pulse |
| start_sid_lock | output | 1 | Secure-region lock pulse |
| erase_susp | output | 1 | Erase suspend pulse |
| erase_resume | output | 1 | Erase resume pulse |
| mode_ident | output | 1 | Identifier read mode |
| mode_query | output | 1 | Parameter-query read mode |
| mode_secid | output | 1 | Secure-region read mode |
| tgt_addr | output | AW (19) | Address latched with the last accepted operation |
| tgt_data | output | DW (16) | Data latched with the last accepted operation |

## Verification
The bench puts junk in the upper address and data bits of the key writes. A decoder that compared full words would then never start a program. It breaks a sequence at its second step and then sends the tail of a program. A design that failed to return to the start would issue a stray program, and one that kept the identifier flag after the abort would be caught at the mode pins. It writes the key while busy and completes it after busy drops, which separates holding the sequence from aborting it. It also writes exit while busy, suspend both with and without busy, and boot-region program and erase with protection on and off. This catches a guard that tests the wrong end of the array or lets chip erase through.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  // Compared width of command addresses
  localparam int unsigned CMD_AW = 11;

  localparam logic [7:0] C_KEY1   = 8'hAA;
  localparam logic [7:0] C_KEY2   = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERPRE  = 8'h80;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_QUERY  = 8'h98;
  localparam logic [7:0] C_SECID  = 8'h88;
  localparam logic [7:0] C_SPROG  = 8'hA5;
  localparam logic [7:0] C_SLOCK  = 8'h85;
  localparam logic [7:0] C_EXIT   = 8'hF0;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h50;
  localparam logic [7:0] C_BLK    = 8'h30;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'h30;

  localparam logic [CMD_AW-1:0] A_KEY1   = 11'h555;
  localparam logic [CMD_AW-1:0] A_KEY2   = 11'h2AA;
  localparam logic [CMD_AW-1:0] A_QSHORT = 11'h055;

  typedef enum logic [3:0] {
    ST_IDLE, ST_K1, ST_K2, ST_WORD, ST_E0, ST_E1, ST_E2, ST_SWORD, ST_SLOCK
  } seq_st_e;

  // Order fixes the pulse bit order: request n drives pulse bit n-1
  typedef enum logic [3:0] {
    RQ_NONE, RQ_PROG, RQ_SECT, RQ_BLK, RQ_CHIP,
    RQ_SPROG, RQ_SLOCK, RQ_SUSP, RQ_RESUME
  } req_e;

  typedef enum logic [1:0] {MD_READ, MD_IDENT, MD_QUERY, MD_SECID} mode_e;

  typedef struct packed {
    logic       key1;
    logic       key2;
    logic       qshort;
    logic [7:0] code;
  } bus_hit_t;

  // True when addr falls in the boot window of 2^bw words at the top or bottom
  function automatic logic in_boot(input logic [31:0] addr, input int aw,
                                   input int bw, input bit top);
    logic [31:0] hi;
    logic [31:0] lim;
    hi  = (addr & ((32'd1 << aw) - 32'd1)) >> bw;
    lim = (32'd1 << (aw - bw)) - 32'd1;
    return top ? (hi == lim) : (hi == 32'd0);
  endfunction

  function automatic logic is_guarded(input req_e r);
    return (r == RQ_PROG) || (r == RQ_SECT) || (r == RQ_BLK);
  endfunction

  function automatic logic carries_target(input req_e r);
    return (r == RQ_PROG) || (r == RQ_SECT) || (r == RQ_BLK) ||
           (r == RQ_CHIP) || (r == RQ_SPROG) || (r == RQ_SLOCK);
  endfunction

endpackage

// File: rtl/fcd_bus_match.sv
module fcd_bus_match
  import fcd_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output bus_hit_t      hit
);
  logic [CMD_AW-1:0] low_addr;
  assign low_addr   = addr[CMD_AW-1:0];
  assign hit.key1   = (low_addr == A_KEY1);
  assign hit.key2   = (low_addr == A_KEY2);
  assign hit.qshort = (low_addr == A_QSHORT);
  assign hit.code   = data[7:0];
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_valid,
  input  logic     busy,
  input  bus_hit_t hit,
  output req_e     req,
  output mode_e    mode,
  output logic     seq_abort
);
  seq_st_e st_q, st_d;
  mode_e   md_q, md_d;

  always_comb begin
    st_d      = st_q;
    md_d      = md_q;
    req       = RQ_NONE;
    seq_abort = 1'b0;
    if (wr_valid) begin
      if (busy) begin
        if (st_q == ST_IDLE && hit.code == C_SUSP) req = RQ_SUSP;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (hit.key1 && hit.code == C_KEY1)          st_d = ST_K1;
            else if (hit.qshort && hit.code == C_QUERY)  md_d = MD_QUERY;
            else if (hit.code == C_EXIT)                 md_d = MD_READ;
            else if (hit.code == C_RESUME)               req  = RQ_RESUME;
          end
          ST_K1: begin
            if (hit.key2 && hit.code == C_KEY2) st_d = ST_K2;
            else                                seq_abort = 1'b1;
          end
          ST_K2: begin
            st_d = ST_IDLE;
            if (!hit.key1) seq_abort = 1'b1;
            else begin
              case (hit.code)
                C_PROG:  st_d = ST_WORD;
                C_ERPRE: st_d = ST_E0;
                C_IDENT: md_d = MD_IDENT;
                C_QUERY: md_d = MD_QUERY;
                C_SECID: md_d = MD_SECID;
                C_SPROG: st_d = ST_SWORD;
                C_SLOCK: st_d = ST_SLOCK;
                C_EXIT:  md_d = MD_READ;
                default: seq_abort = 1'b1;
              endcase
            end
          end
          ST_WORD: begin
            req  = RQ_PROG;
            st_d = ST_IDLE;
          end
          ST_E0: begin
            if (hit.key1 && hit.code == C_KEY1) st_d = ST_E1;
            else                                seq_abort = 1'b1;
          end
          ST_E1: begin
            if (hit.key2 && hit.code == C_KEY2) st_d = ST_E2;
            else                                seq_abort = 1'b1;
          end
          ST_E2: begin
            st_d = ST_IDLE;
            if (hit.key1 && hit.code == C_CHIP) req = RQ_CHIP;
            else if (hit.code == C_SECT)        req = RQ_SECT;
            else if (hit.code == C_BLK)         req = RQ_BLK;
            else                                seq_abort = 1'b1;
          end
          ST_SWORD: begin
            req  = RQ_SPROG;
            st_d = ST_IDLE;
          end
          ST_SLOCK: begin
            req  = RQ_SLOCK;
            st_d = ST_IDLE;
          end
          default: st_d = ST_IDLE;
        endcase
        if (seq_abort) begin
          st_d = ST_IDLE;
          md_d = MD_READ;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      md_q <= MD_READ;
    end else begin
      st_q <= st_d;
      md_q <= md_d;
    end
  end

  assign mode = md_q;
endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import fcd_pkg::*;
#(
  parameter int unsigned AW       = 19,
  parameter int unsigned BOOT_W   = 13,
  parameter bit          BOOT_TOP = 1'b1
) (
  input  req_e          req,
  input  logic [AW-1:0] addr,
  input  logic          wp_n,
  output logic          allow
);
  logic boot_hit;
  assign boot_hit = in_boot(32'(addr), AW, BOOT_W, BOOT_TOP);
  assign allow    = wp_n || !((req == RQ_CHIP) || (is_guarded(req) && boot_hit));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned AW       = 19,
  parameter int unsigned DW       = 16,
  parameter int unsigned BOOT_W   = 13,
  parameter bit          BOOT_TOP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  input  logic          wp_n,
  output logic          start_prog,
  output logic          start_sect_erase,
  output logic          start_blk_erase,
  output logic          start_chip_erase,
  output logic          start_sid_prog,
  output logic          start_sid_lock,
  output logic          erase_susp,
  output logic          erase_resume,
  output logic          mode_ident,
  output logic          mode_query,
  output logic          mode_secid,
  output logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] tgt_data
);
  localparam int unsigned NPULSE = 8;

  bus_hit_t          hit;
  req_e              req;
  mode_e             mode;
  logic              seq_abort;
  logic              allow;
  logic              cmd_dropped;
  logic              take_target;
  logic [NPULSE-1:0] pulse_q;

  fcd_bus_match #(.AW(AW), .DW(DW)) match_i (
    .addr (wr_addr),
    .data (wr_data),
    .hit  (hit)
  );

  fcd_seq_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .busy      (busy),
    .hit       (hit),
    .req       (req),
    .mode      (mode),
    .seq_abort (seq_abort)
  );

  fcd_guard #(.AW(AW), .BOOT_W(BOOT_W), .BOOT_TOP(BOOT_TOP)) guard_i (
    .req   (req),
    .addr  (wr_addr),
    .wp_n  (wp_n),
    .allow (allow)
  );

  assign cmd_dropped = (req != RQ_NONE) && !allow;
  assign take_target = carries_target(req) && allow;

  for (genvar gi = 0; gi < NPULSE; gi++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[gi] <= 1'b0;
      else        pulse_q[gi] <= (req == req_e'(4'(gi + 1))) && allow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      tgt_data <= '0;
    end else if (take_target) begin
      tgt_addr <= wr_addr;
      tgt_data <= wr_data;
    end
  end

  assign start_prog       = pulse_q[0];
  assign start_sect_erase = pulse_q[1];
  assign start_blk_erase  = pulse_q[2];
  assign start_chip_erase = pulse_q[3];
  assign start_sid_prog   = pulse_q[4];
  assign start_sid_lock   = pulse_q[5];
  assign erase_susp       = pulse_q[6];
  assign erase_resume     = pulse_q[7];

  assign mode_ident = (mode == MD_IDENT);
  assign mode_query = (mode == MD_QUERY);
  assign mode_secid = (mode == MD_SECID);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned AW       = 19,
  parameter int unsigned BOOT_W   = 13,
  parameter bit          BOOT_TOP = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          busy,
  input logic          wp_n,
  input logic [7:0]    pulses,
  input logic [2:0]    modes,
  input logic [AW-1:0] tgt_addr,
  input logic          seq_abort,
  input logic          cmd_dropped
);
  logic [AW-BOOT_W-1:0] tgt_hi;
  logic                 tgt_in_boot;
  assign tgt_hi      = tgt_addr[AW-1:BOOT_W];
  assign tgt_in_boot = BOOT_TOP ? (&tgt_hi) : ~(|tgt_hi);

  p_one_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  p_pulse_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses != 8'h00) |-> $past(wr_valid));

  p_prog_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulses[0] |=> !pulses[0]);

  p_modes_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(modes));

  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid) |=> ((pulses & 8'hBF) == 8'h00));

  p_busy_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(modes));

  p_susp_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulses[6] |-> $past(busy));

  p_chip_wp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulses[3] |-> $past(wp_n));

  p_boot_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses[0] && !$past(wp_n)) |-> !tgt_in_boot);

  p_dropped_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dropped |=> (pulses == 8'h00));

  p_abort_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (modes == 3'b000) && (pulses == 8'h00));
endmodule

bind flash_cmd_decoder fcd_checker #(
  .AW(AW), .BOOT_W(BOOT_W), .BOOT_TOP(BOOT_TOP)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .busy        (busy),
  .wp_n        (wp_n),
  .pulses      (pulse_q),
  .modes       ({mode_secid, mode_query, mode_ident}),
  .tgt_addr    (tgt_addr),
  .seq_abort   (seq_abort),
  .cmd_dropped (cmd_dropped)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int AW = 19;
  localparam int DW = 16;

  typedef struct packed {
    logic [18:0] a;
    logic [15:0] d;
    logic        wp;
    logic        bz;
    logic [7:0]  p;
    logic [2:0]  m;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 46;
  // Pulse bits: 0 prog,1 sect,2 blk,3 chip,4 sid_prog,5 sid_lock,6 susp,7 resume
  // Mode bits: 0 ident,1 query,2 secid
  localparam vec_t VEC [NV] = '{
    // R2: key writes with junk upper bits; R3 program
    '{19'h7D555, 16'h12AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd2},
    '{19'h402AA, 16'hFF55, 1'b1, 1'b0, 8'h00, 3'b000, 4'd2},
    '{19'h00555, 16'h00A0, 1'b1, 1'b0, 8'h00, 3'b000, 4'd3},
    '{19'h12345, 16'hBEEF, 1'b1, 1'b0, 8'h01, 3'b000, 4'd3},
    // R4 sector erase
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h00555, 16'h0080, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h23800, 16'h0050, 1'b1, 1'b0, 8'h02, 3'b000, 4'd4},
    // R4 block erase
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h00555, 16'h0080, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h40000, 16'h0030, 1'b1, 1'b0, 8'h04, 3'b000, 4'd4},
    // R4 chip erase
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h00555, 16'h0080, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd4},
    '{19'h00555, 16'h0010, 1'b1, 1'b0, 8'h08, 3'b000, 4'd4},
    // R6 identifier entry
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd6},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd6},
    '{19'h00555, 16'h0090, 1'b1, 1'b0, 8'h00, 3'b001, 4'd6},
    // R7 single exit
    '{19'h01234, 16'h00F0, 1'b1, 1'b0, 8'h00, 3'b000, 4'd7},
    // R6 query shortcut, then secure entry replaces it
    '{19'h00055, 16'h0098, 1'b1, 1'b0, 8'h00, 3'b010, 4'd6},
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b010, 4'd6},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b010, 4'd6},
    '{19'h00555, 16'h0088, 1'b1, 1'b0, 8'h00, 3'b100, 4'd6},
    // R7 keyed exit
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b100, 4'd7},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b100, 4'd7},
    '{19'h00555, 16'h00F0, 1'b1, 1'b0, 8'h00, 3'b000, 4'd7},
    // R8 abort at step two, program tail must then be ignored
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd8},
    '{19'h002AB, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd8},
    '{19'h00555, 16'h00A0, 1'b1, 1'b0, 8'h00, 3'b000, 4'd8},
    '{19'h12345, 16'h1111, 1'b1, 1'b0, 8'h00, 3'b000, 4'd8},
    // R11 secure program and lock
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd11},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd11},
    '{19'h00555, 16'h00A5, 1'b1, 1'b0, 8'h00, 3'b000, 4'd11},
    '{19'h00010, 16'h5A5A, 1'b0, 1'b0, 8'h10, 3'b000, 4'd11},
    '{19'h00555, 16'h00AA, 1'b1, 1'b0, 8'h00, 3'b000, 4'd11},
    '{19'h002AA, 16'h0055, 1'b1, 1'b0, 8'h00, 3'b000, 4'd11},
    '{19'h00555, 16'h0085, 1'b1, 1'b0, 8'h00, 3'b000, 4'd11},
    '{19'h00000, 16'h0000, 1'b1, 1'b0, 8'h20, 3'b000, 4'd11},
    // R5 resume
    '{19'h3FFFF, 16'h0030, 1'b1, 1'b0, 8'h80, 3'b000, 4'd5}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          wp_n = 1'b1;
  logic          start_prog, start_sect_erase, start_blk_erase, start_chip_erase;
  logic          start_sid_prog, start_sid_lock, erase_susp, erase_resume;
  logic          mode_ident, mode_query, mode_secid;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;

  int   checks = 0;
  int   errors = 0;
  logic [7:0] seen;

  always #2.5 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .wp_n(wp_n),
    .start_prog(start_prog), .start_sect_erase(start_sect_erase),
    .start_blk_erase(start_blk_erase), .start_chip_erase(start_chip_erase),
    .start_sid_prog(start_sid_prog), .start_sid_lock(start_sid_lock),
    .erase_susp(erase_susp), .erase_resume(erase_resume),
    .mode_ident(mode_ident), .mode_query(mode_query), .mode_secid(mode_secid),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  function automatic logic [7:0] pulses();
    return {erase_resume, erase_susp, start_sid_lock, start_sid_prog,
            start_chip_erase, start_blk_erase, start_sect_erase, start_prog};
  endfunction

  function automatic logic [2:0] modes();
    return {mode_secid, mode_query, mode_ident};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus write; returns at the negedge after the capturing edge
  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    seen = seen | pulses();
  endtask

  task automatic unlock();
    wr(19'h00555, 16'h00AA);
    wr(19'h002AA, 16'h0055);
  endtask

  task automatic prog(input logic [18:0] a, input logic [15:0] d);
    unlock();
    wr(19'h00555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase(input logic [18:0] a, input logic [7:0] code);
    unlock();
    wr(19'h00555, 16'h0080);
    unlock();
    wr(a, {8'h00, code});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pulses", 32'(pulses()), 32'h0);
    check("R1 modes", 32'(modes()), 32'h0);
    check("R1 tgt_addr", 32'(tgt_addr), 32'h0);
    check("R1 tgt_data", 32'(tgt_data), 32'h0);

    // Vector walk (R2..R8, R11, R5)
    for (int i = 0; i < NV; i++) begin
      wp_n = VEC[i].wp;
      busy = VEC[i].bz;
      wr(VEC[i].a, VEC[i].d);
      check($sformatf("R%0d vec %0d pulses", VEC[i].r, i), 32'(pulses()), 32'(VEC[i].p));
      check($sformatf("R%0d vec %0d modes", VEC[i].r, i), 32'(modes()), 32'(VEC[i].m));
    end
    wp_n = 1'b1;

    // R3 target capture and R12 single-cycle pulse
    prog(19'h0ABCD, 16'hC3C3);
    check("R3 start_prog", 32'(start_prog), 32'h1);
    check("R3 tgt_addr", 32'(tgt_addr), 32'h0ABCD);
    check("R3 tgt_data", 32'(tgt_data), 32'hC3C3);
    @(negedge clk);
    check("R12 pulse width", 32'(pulses()), 32'h0);

    // R8 abort leaves identifier mode
    unlock();
    wr(19'h00555, 16'h0090);
    check("R6 ident set", 32'(modes()), 32'h1);
    wr(19'h00555, 16'h00AA);
    wr(19'h002AB, 16'h0055);
    check("R8 abort clears mode", 32'(modes()), 32'h0);

    // R9 busy ignores a full program and the exit write
    busy = 1'b1;
    seen = '0;
    prog(19'h01000, 16'h1234);
    check("R9 busy program ignored", 32'(seen), 32'h0);
    busy = 1'b0;
    unlock();
    wr(19'h00555, 16'h0090);
    busy = 1'b1;
    wr(19'h00123, 16'h00F0);
    check("R9 busy exit ignored", 32'(modes()), 32'h1);
    // R5 suspend only while busy
    wr(19'h00123, 16'h00B0);
    check("R5 suspend while busy", 32'(pulses()), 32'h40);
    busy = 1'b0;
    wr(19'h00123, 16'h00B0);
    check("R5 suspend when idle", 32'(pulses()), 32'h0);
    wr(19'h00000, 16'h00F0);
    check("R7 exit", 32'(modes()), 32'h0);

    // R9 sequence position held across busy
    wr(19'h00555, 16'h00AA);
    busy = 1'b1;
    wr(19'h002AA, 16'h0055);
    busy = 1'b0;
    wr(19'h002AA, 16'h0055);
    wr(19'h00555, 16'h00A0);
    wr(19'h05000, 16'h7777);
    check("R9 hold then program", 32'(pulses()), 32'h01);

    // R10 write protection
    wp_n = 1'b0;
    prog(19'h7F000, 16'h0001);
    check("R10 boot program blocked", 32'(pulses()), 32'h0);
    prog(19'h10000, 16'h0002);
    check("R10 outside program allowed", 32'(pulses()), 32'h01);
    erase(19'h7E800, 8'h50);
    check("R10 boot sector blocked", 32'(pulses()), 32'h0);
    erase(19'h7E000, 8'h30);
    check("R10 boot block blocked", 32'(pulses()), 32'h0);
    erase(19'h00555, 8'h10);
    check("R10 chip refused", 32'(pulses()), 32'h0);
    erase(19'h01800, 8'h50);
    check("R10 bottom sector allowed", 32'(pulses()), 32'h02);
    wp_n = 1'b1;
    erase(19'h7E800, 8'h50);
    check("R10 boot sector unprotected", 32'(pulses()), 32'h02);
    check("R4 sector target", 32'(tgt_addr), 32'h7E800);

    // R1 reset clears a mode
    wr(19'h00055, 16'h0098);
    check("R6 query shortcut", 32'(modes()), 32'h2);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mode", 32'(modes()), 32'h0);
    check("R1 reset target", 32'(tgt_addr), 32'h0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule